// File: doc/BRIEF.md
# Second-Operand Shifter with Carry-Out

This block shapes the second ALU operand of a 32-bit datapath in one purely combinational step. A form select picks one of four operand forms. The first shifts or rotates a register by a small immediate amount. The second does the same using an amount read from another register. The third rotates right by one bit through the carry flag. The fourth rotates an 8-bit immediate into a 32-bit constant.

Next to the shaped operand, the block outputs the shifter carry that the ALU would use for flag-setting logical operations. Register-file reads, instruction decode, the ALU and flag writeback all sit outside this block. All inputs must be stable before the consuming stage samples the outputs.

Top module: `op2_shifter`

## Requirements
- R1: With form_sel=0 (immediate amount) and imm_amt in 1..31, shift_kind selects the operation: 0 is logical left, 1 is logical right, 2 is arithmetic right and 3 is rotate right. The carry for a left shift is bit 32-n of the value. For logical or arithmetic right shifts it is bit n-1. For a rotate it is bit 31 of the result.
- R2: An amount of zero passes the value through unchanged and copies carry_in to carry_out. This holds for an immediate amount of 0 under form_sel=0 and for a register amount of 0 under form_sel=1, for every shift_kind.
- R3: With form_sel=1 (register amount), only bits 7:0 of amt_reg give the amount. Bits 31:8 have no effect on either output.
- R4: A register-amount logical shift by exactly 32 gives a result of 0. The carry is bit 0 of the value for a left shift and bit 31 for a right shift.
- R5: A register-amount logical shift by 33..255 gives a result of 0 and a carry of 0.
- R6: A register-amount arithmetic right shift by 32 or more fills every bit with bit 31 of the value, and the carry equals that bit.
- R7: A register-amount rotate by a nonzero multiple of 32 returns the value unchanged, with carry equal to bit 31. Any other nonzero amount rotates right by the amount modulo 32, and the carry is bit 31 of the result.
- R8: With form_sel=2, the result is carry_in followed by value bits 31:1, and carry_out is value bit 0.
- R9: With form_sel=3, imm_val is zero-extended and rotated right by twice imm_rot. For example, imm_val=0xFF with imm_rot=2 gives 0xF000000F.
- R10: With form_sel=3, carry_out equals carry_in when imm_rot is 0. Otherwise it equals bit 31 of the result.
- R11: Fields that the selected form does not use have no effect on the outputs. This covers shift_kind and both amounts under forms 2 and 3, amt_reg under form 0, and imm_amt under form 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_val | input | 32 | Register value to be shifted or rotated |
| amt_reg | input | 32 | Register holding the shift amount (low 8 bits used) |
| carry_in | input | 1 | Current carry flag |
| shift_kind | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| form_sel | input | 2 | 0 immediate amount, 1 register amount, 2 rotate-through-carry, 3 rotated immediate |
| imm_amt | input | 5 | Immediate shift amount |
| imm_val | input | 8 | Immediate constant byte |
| imm_rot | input | 4 | Immediate rotate field (rotation = 2 x field) |
| op2_out | output | 32 | Shaped second operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The block holds no state, so a fault in its internal shift, clamp or carry-select paths appears at op2_out or carry_out in the same cycle as the input pattern that exercises it. The faults most likely to stay hidden are in the carry at amount boundaries: 0, 1, 31, 32, 33, multiples of 32 for rotates, and a rotate field of 0. The bench drives each of these directly. A random sweep that draws amounts near the boundaries while also setting high register bits catches a mis-sliced amount.

// File: rtl/op2_shifter_pkg.sv
`timescale 1ns/1ps
package op2_shifter_pkg;
   typedef enum logic [1:0] {
      K_LSL = 2'd0,
      K_LSR = 2'd1,
      K_ASR = 2'd2,
      K_ROR = 2'd3
   } shift_kind_e;

   typedef enum logic [1:0] {
      F_IMM_AMT = 2'd0,
      F_REG_AMT = 2'd1,
      F_RRX     = 2'd2,
      F_ROT_IMM = 2'd3
   } op2_form_e;
endpackage

// File: rtl/op2_shift_core.sv
`timescale 1ns/1ps
module op2_shift_core
   import op2_shifter_pkg::*;
#(
   parameter int DW     = 32,
   parameter int AW     = 8,
   parameter bit STAGED = 1'b1
) (
   input  logic [DW-1:0] val,
   input  logic [AW-1:0] amt,
   input  shift_kind_e   kind,
   input  logic          cin,
   output logic [DW-1:0] res,
   output logic          cout
);
   localparam int LW = $clog2(DW);

   if ((1 << LW) != DW) begin : g_chk_pow2
      $error("op2_shift_core: DW must be a power of two");
   end
   if ((1 << AW) <= DW) begin : g_chk_aw
      $error("op2_shift_core: AW too narrow to encode DW");
   end

   logic          big;
   logic [AW-1:0] amt_c;
   logic [LW-1:0] rot_n;
   logic [DW:0]   lsl_x;
   logic [DW:0]   lsr_x;
   logic [DW:0]   asr_x;
   logic [DW-1:0] ror_v;

   assign big   = (amt > AW'(DW));
   assign amt_c = big ? AW'(DW) : amt;
   assign rot_n = amt[LW-1:0];
   assign lsl_x = {1'b0, val} << amt_c;
   assign lsr_x = {val, 1'b0} >> amt_c;
   assign asr_x = $unsigned($signed({val, 1'b0}) >>> amt_c);

   if (STAGED) begin : g_ror_staged
      logic [DW-1:0] st [0:LW];
      assign st[0] = val;
      for (genvar k = 0; k < LW; k++) begin : g_stage
         localparam int SH = 1 << k;
         assign st[k+1] = rot_n[k] ? {st[k][SH-1:0], st[k][DW-1:SH]} : st[k];
      end
      assign ror_v = st[LW];
   end else begin : g_ror_flat
      assign ror_v = (val >> rot_n) | (val << (DW - int'(rot_n)));
   end

   always_comb begin
      res  = val;
      cout = cin;
      if (amt != '0) begin
         unique case (kind)
            K_LSL: begin
               res  = big ? '0   : lsl_x[DW-1:0];
               cout = big ? 1'b0 : lsl_x[DW];
            end
            K_LSR: begin
               res  = big ? '0   : lsr_x[DW:1];
               cout = big ? 1'b0 : lsr_x[0];
            end
            K_ASR: begin
               res  = asr_x[DW:1];
               cout = asr_x[0];
            end
            K_ROR: begin
               res  = ror_v;
               cout = ror_v[DW-1];
            end
         endcase
      end
   end

   always_comb begin
      p_zero_amt_pass_r2: assert ((amt != '0) || (res == val && cout == cin))
         else $error("zero amount altered operand");
      p_big_logical_zero_r5: assert (!(big && (kind == K_LSL || kind == K_LSR))
                                     || (res == '0 && cout == 1'b0))
         else $error("logical overshift not zero");
      p_asr_sign_fill_r6: assert (!(kind == K_ASR && amt >= AW'(DW))
                                  || (res == {DW{val[DW-1]}} && cout == val[DW-1]))
         else $error("arith overshift not sign filled");
      p_ror_popcount_r7: assert (kind != K_ROR || $countones(res) == $countones(val))
         else $error("rotate changed bit count");
   end
endmodule

// File: rtl/op2_rot_imm.sv
`timescale 1ns/1ps
module op2_rot_imm #(
   parameter int DW = 32,
   parameter int IW = 8,
   parameter int RW = 4
) (
   input  logic [IW-1:0] imm,
   input  logic [RW-1:0] rot,
   input  logic          cin,
   output logic [DW-1:0] res,
   output logic          cout
);
   if ((1 << (RW + 1)) > DW) begin : g_chk_rot
      $error("op2_rot_imm: rotate field reaches past DW");
   end
   if (IW > DW) begin : g_chk_iw
      $error("op2_rot_imm: immediate wider than data");
   end

   logic [DW-1:0] ext;
   logic [RW:0]   rsh;

   assign ext  = DW'(imm);
   assign rsh  = {rot, 1'b0};
   assign res  = (ext >> rsh) | (ext << (DW - int'(rsh)));
   assign cout = (rot == '0) ? cin : res[DW-1];

   always_comb begin
      p_rot_imm_bits_r9: assert ($countones(res) == $countones(imm))
         else $error("rotated immediate lost bits");
      p_rot_imm_carry_r10: assert ((rot == '0) ? (cout == cin) : (cout == res[DW-1]))
         else $error("rotated immediate carry wrong");
   end
endmodule

// File: rtl/op2_shifter.sv
`timescale 1ns/1ps
module op2_shifter
   import op2_shifter_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int REG_AW   = 8,
   parameter int IMM_W    = 8,
   parameter int ROT_W    = 4,
   parameter bit STAGED   = 1'b1,
   localparam int IMM_AW  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] op_val,
   input  logic [DATA_W-1:0] amt_reg,
   input  logic              carry_in,
   input  logic [1:0]        shift_kind,
   input  logic [1:0]        form_sel,
   input  logic [IMM_AW-1:0] imm_amt,
   input  logic [IMM_W-1:0]  imm_val,
   input  logic [ROT_W-1:0]  imm_rot,
   output logic [DATA_W-1:0] op2_out,
   output logic              carry_out
);
   if (REG_AW >= DATA_W) begin : g_chk_regaw
      $error("op2_shifter: REG_AW must be below DATA_W");
   end
   if (REG_AW <= IMM_AW) begin : g_chk_immaw
      $error("op2_shifter: REG_AW must exceed immediate amount width");
   end

   op2_form_e   form;
   shift_kind_e kind;
   logic [REG_AW-1:0] core_amt;
   logic [DATA_W-1:0] core_res, rimm_res, rrx_res;
   logic              core_c, rimm_c, rrx_c;
   logic              unused_amt_hi;

   assign form          = op2_form_e'(form_sel);
   assign kind          = shift_kind_e'(shift_kind);
   assign unused_amt_hi = ^amt_reg[DATA_W-1:REG_AW];
   assign core_amt      = (form == F_IMM_AMT) ? REG_AW'(imm_amt) : amt_reg[REG_AW-1:0];
   assign rrx_res       = {carry_in, op_val[DATA_W-1:1]};
   assign rrx_c         = op_val[0];

   op2_shift_core #(
      .DW     (DATA_W),
      .AW     (REG_AW),
      .STAGED (STAGED)
   ) i_core (
      .val  (op_val),
      .amt  (core_amt),
      .kind (kind),
      .cin  (carry_in),
      .res  (core_res),
      .cout (core_c)
   );

   op2_rot_imm #(
      .DW (DATA_W),
      .IW (IMM_W),
      .RW (ROT_W)
   ) i_rimm (
      .imm  (imm_val),
      .rot  (imm_rot),
      .cin  (carry_in),
      .res  (rimm_res),
      .cout (rimm_c)
   );

   always_comb begin
      unique case (form)
         F_IMM_AMT, F_REG_AMT: begin
            op2_out   = core_res;
            carry_out = core_c;
         end
         F_RRX: begin
            op2_out   = rrx_res;
            carry_out = rrx_c;
         end
         F_ROT_IMM: begin
            op2_out   = rimm_res;
            carry_out = rimm_c;
         end
      endcase
   end

   always_comb begin
      p_rrx_shape_r8: assert (form != F_RRX
                              || (op2_out[DATA_W-1] == carry_in && carry_out == op_val[0]
                                  && op2_out[DATA_W-2:0] == op_val[DATA_W-1:1]))
         else $error("rotate through carry wrong");
      p_imm_form_count_r1: assert (!(form == F_IMM_AMT && kind == K_ROR)
                                   || $countones(op2_out) == $countones(op_val))
         else $error("immediate rotate changed bit count");
   end
endmodule

// File: tb/test_op2_shifter.sv
`timescale 1ns/1ps
module test_op2_shifter;
   logic        clk = 1'b0;
   logic [31:0] op_val = '0, amt_reg = '0;
   logic        carry_in = 1'b0;
   logic [1:0]  shift_kind = '0, form_sel = '0;
   logic [4:0]  imm_amt = '0;
   logic [7:0]  imm_val = '0;
   logic [3:0]  imm_rot = '0;
   logic [31:0] op2_out;
   logic        carry_out;
   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   op2_shifter i_op2_shifter (
      .op_val(op_val), .amt_reg(amt_reg), .carry_in(carry_in),
      .shift_kind(shift_kind), .form_sel(form_sel), .imm_amt(imm_amt),
      .imm_val(imm_val), .imm_rot(imm_rot), .op2_out(op2_out), .carry_out(carry_out)
   );

   function automatic logic [32:0] model(logic [1:0] f, logic [1:0] k, logic [31:0] v,
                                         logic [31:0] a, logic c, logic [4:0] i5,
                                         logic [7:0] i8, logic [3:0] r4);
      logic [31:0] r = '0;
      logic        co = c;
      int n;
      if (f == 2'd2) return {v[0], c, v[31:1]};
      if (f == 2'd3) begin
         n = 2 * int'(r4);
         for (int i = 0; i < 32; i++) begin
            int src = (i + n) % 32;
            r[i] = (src < 8) ? i8[src] : 1'b0;
         end
         return {(n == 0) ? c : r[31], r};
      end
      n = (f == 2'd0) ? int'(i5) : int'(a[7:0]);
      if (n == 0) return {c, v};
      case (k)
         2'd0: begin
            for (int i = 0; i < 32; i++) r[i] = (i >= n) ? v[i-n] : 1'b0;
            co = (n <= 32) ? v[32-n] : 1'b0;
         end
         2'd1: begin
            for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? v[i+n] : 1'b0;
            co = (n <= 32) ? v[n-1] : 1'b0;
         end
         2'd2: begin
            for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? v[i+n] : v[31];
            co = (n >= 32) ? v[31] : v[n-1];
         end
         default: begin
            for (int i = 0; i < 32; i++) r[i] = v[(i + n) % 32];
            co = r[31];
         end
      endcase
      return {co, r};
   endfunction

   task automatic run(string tag, logic [1:0] f, logic [1:0] k, logic [31:0] v,
                      logic [31:0] a, logic c, logic [4:0] i5, logic [7:0] i8,
                      logic [3:0] r4);
      logic [32:0] exp;
      @(posedge clk);
      form_sel = f; shift_kind = k; op_val = v; amt_reg = a; carry_in = c;
      imm_amt = i5; imm_val = i8; imm_rot = r4;
      exp = model(f, k, v, a, c, i5, i8, r4);
      @(negedge clk);
      checks++;
      if (op2_out !== exp[31:0] || carry_out !== exp[32]) begin
         failures++;
         $display("FAIL %s: got res=%h c=%b expected res=%h c=%b", tag,
                  op2_out, carry_out, exp[31:0], exp[32]);
      end
   endtask

   function automatic string tag_of(logic [1:0] f);
      case (f)
         2'd0: return "R1";
         2'd1: return "R3";
         2'd2: return "R8";
         default: return "R9";
      endcase
   endfunction

   initial begin
      int seed = $urandom(32'd2024);
      if (seed < 0) $display("seed");
      @(negedge clk);
      checks++;
      if (op2_out !== 32'h0 || carry_out !== 1'b0) begin
         failures++;
         $display("FAIL R2: reset-state got res=%h c=%b expected res=0 c=0", op2_out, carry_out);
      end
      // R1 immediate-amount shifts
      run("R1", 2'd0, 2'd0, 32'h8000_0001, 0, 0, 5'd1, 0, 0);
      run("R1", 2'd0, 2'd1, 32'h0000_00F1, 0, 0, 5'd4, 0, 0);
      run("R1", 2'd0, 2'd2, 32'h8000_0010, 0, 0, 5'd31, 0, 0);
      run("R1", 2'd0, 2'd3, 32'h1234_5678, 0, 0, 5'd8, 0, 0);
      // R2 zero amounts keep value and carry
      run("R2", 2'd0, 2'd0, 32'hDEAD_BEEF, 0, 1, 5'd0, 0, 0);
      run("R2", 2'd0, 2'd3, 32'hDEAD_BEEF, 0, 0, 5'd0, 0, 0);
      run("R2", 2'd1, 2'd2, 32'h8000_0000, 32'h0000_0000, 1, 0, 0, 0);
      // R3 upper amount bits ignored
      run("R3", 2'd1, 2'd1, 32'hF000_0000, 32'hFFFF_FF04, 0, 0, 0, 0);
      run("R3", 2'd1, 2'd0, 32'h0000_00FF, 32'h1234_5600, 1, 0, 0, 0);
      // R4 shift by 32
      run("R4", 2'd1, 2'd0, 32'h0000_0001, 32'd32, 0, 0, 0, 0);
      run("R4", 2'd1, 2'd1, 32'h8000_0000, 32'd32, 0, 0, 0, 0);
      // R5 beyond 32
      run("R5", 2'd1, 2'd0, 32'hFFFF_FFFF, 32'd33, 1, 0, 0, 0);
      run("R5", 2'd1, 2'd1, 32'hFFFF_FFFF, 32'd255, 1, 0, 0, 0);
      // R6 arithmetic overshift
      run("R6", 2'd1, 2'd2, 32'h8000_0000, 32'd32, 0, 0, 0, 0);
      run("R6", 2'd1, 2'd2, 32'h7FFF_FFFF, 32'd200, 1, 0, 0, 0);
      // R7 register rotate
      run("R7", 2'd1, 2'd3, 32'h8000_0002, 32'd64, 0, 0, 0, 0);
      run("R7", 2'd1, 2'd3, 32'h0000_0003, 32'd33, 0, 0, 0, 0);
      // R8 rotate through carry
      run("R8", 2'd2, 2'd0, 32'h0000_0003, 0, 1, 0, 0, 0);
      run("R8", 2'd2, 2'd3, 32'h8000_0002, 0, 0, 0, 0, 0);
      // R9 / R10 rotated immediate
      run("R9", 2'd3, 2'd0, 0, 0, 0, 0, 8'hFF, 4'd2);
      checks++;
      if (op2_out !== 32'hF000_000F) begin
         failures++;
         $display("FAIL R9: got res=%h expected res=f000000f", op2_out);
      end
      run("R10", 2'd3, 2'd0, 0, 0, 1, 0, 8'h01, 4'd0);
      run("R10", 2'd3, 2'd0, 0, 0, 1, 0, 8'h02, 4'd1);
      // R11 unused fields ignored
      run("R11", 2'd2, 2'd2, 32'h5555_5555, 32'hFFFF_FFFF, 1, 5'd31, 8'hAA, 4'd7);
      run("R11", 2'd3, 2'd1, 32'hFFFF_FFFF, 32'd40, 0, 5'd9, 8'h81, 4'd1);
      run("R11", 2'd0, 2'd1, 32'hF0F0_F0F0, 32'd200, 0, 5'd3, 0, 0);
      run("R11", 2'd1, 2'd1, 32'hF0F0_F0F0, 32'd3, 0, 5'd20, 0, 0);
      for (int t = 0; t < 3000; t++) begin
         logic [1:0]  f = 2'($urandom);
         logic [31:0] a = $urandom;
         if ($urandom % 2 == 0) a[7:0] = 8'($urandom % 70);
         run(tag_of(f), f, 2'($urandom), $urandom, a, 1'($urandom),
             5'($urandom), 8'($urandom), 4'($urandom));
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule